// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block generates eight pulse-width-modulated outputs from one up-counter, so every channel runs at the same period and only the duty differs between channels. Software programs the timer over a simple 32-bit register bus. It chooses the clock source that drives the counter and a power-of-two prescaler. It also sets the value the counter restarts from and the value at which it wraps. The counter value can be read back at any time.

Each channel has a small configuration field that selects edge-aligned PWM and a compare value that sets its duty. Three per-channel bits decide how the output behaves: one inverts it, one masks it, and one enables it. A masked, disabled or non-PWM channel holds its inactive level, and the polarity bit is applied to that level as well. All outputs leave reset masked.

The bus is a single-cycle, word-addressed strobe interface with byte addresses. Writes take effect at the clock edge on which `req_i` and `we_i` are both high. While `req_i` is high and `we_i` is low, read data is valid in the same cycle.

Top module: `pwm_timer`

## Requirements
- R1: After reset the control register (0x00) reads 0, the counter (0x04) reads 0, the polarity register (0x70) reads 0, the mask register (0x60) reads 0xFF, and every `pwm_o` bit is 0.
- R2: When the clock-select field (control bits 4:3) is 0, the counter holds its value on every cycle, whatever the tick inputs do.
- R3: The 3-bit prescaler field is control bits 2:0 and holds PS. With clock select 1 (the system clock, every cycle), the counter advances once every 2^PS cycles, for PS from 0 to 7.
- R4: Clock select 2 counts only on cycles where `fix_tick_i` is high, and clock select 3 counts only on cycles where `ext_tick_i` is high. The prescaler counts those qualified cycles.
- R5: On each advance, a counter value equal to or above the modulo register (0x08) is replaced by the restart register (0x4C); any other value increments by one.
- R6: Edge-aligned PWM drives the raw output active while counter < compare and inactive otherwise. A compare of 0 gives an always-inactive output, and a compare above the modulo gives an always-active output.
- R7: Channel n has a configuration register at 0x0C+8n and a compare register at 0x10+8n. The channel is in PWM mode only when configuration bits 5 and 3 are both 1; in any other setting its raw output is inactive.
- R8: Polarity bit n (0x70) set to 1 inverts `pwm_o[n]`, with the inactive level becoming 1.
- R9: A channel whose mask bit n (0x60) is 1, or whose enable bit (control bit 16+n) is 0, drives its inactive level after polarity, that is `pwm_o[n]` = polarity bit n.
- R10: Reads of the counter return its live value, and writes to it are ignored. Addresses that are not implemented, including unaligned ones, read as zero and ignore writes.
- R11: Implemented fields read back as written. Configuration registers keep bits 5:2 only, and the compare, modulo and restart registers keep their low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the system count source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fix_tick_i | input | 1 | Count qualifier for clock select 2 |
| ext_tick_i | input | 1 | Count qualifier for clock select 3 |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| pwm_o | output | 8 | Channel outputs |

## Verification
The hardest situations to reach from the ports are the interaction of the prescaler phase with gated tick inputs, and a restart value that is non-zero while the counter already sits above a newly programmed modulo. A table of configurations is walked with the counter stopped during reprogramming. The bench reads the live counter once to seed its own counter model, then starts the clock and drives pseudo-random tick qualifiers. On every cycle it compares the counter read port and all eight outputs against the model. The table includes compares of 0 and above the modulo, every clock source, a prescaler of 7, partial configuration bits, and mixed mask, enable and polarity patterns.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PS_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT     = 8'h04;
  localparam logic [ADDR_W-1:0] A_MOD     = 8'h08;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h0C;
  localparam logic [ADDR_W-1:0] A_START   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'h60;
  localparam logic [ADDR_W-1:0] A_POL     = 8'h70;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic [CNT_W-1:0]              cnt_i,
  output logic [31:0]                   rdata_o,
  output logic [PS_W-1:0]               ps_o,
  output src_e                          sel_o,
  output logic [CNT_W-1:0]              mod_o,
  output logic [CNT_W-1:0]              start_o,
  output logic [NCH-1:0]                en_o,
  output logic [NCH-1:0]                mask_o,
  output logic [NCH-1:0]                pol_o,
  output logic [NCH-1:0]                mode_o,
  output logic [NCH-1:0][CNT_W-1:0]     cmp_o
);
  localparam int unsigned IDX_W = $clog2(NCH);
  localparam logic [ADDR_W-1:0] CH_END = ADDR_W'(A_CH_BASE + 8 * NCH);

  logic              wr;
  logic              ch_hit;
  logic [ADDR_W-1:0] ch_off;
  logic [IDX_W-1:0]  ch_idx;
  logic              ch_is_cmp;
  logic [3:0]        cfg_q [NCH];
  logic              unused_bits;

  assign wr        = req_i & we_i;
  assign ch_off    = addr_i - A_CH_BASE;
  assign ch_hit    = (addr_i >= A_CH_BASE) && (addr_i < CH_END) && (addr_i[1:0] == 2'b00);
  assign ch_idx    = ch_off[3 +: IDX_W];
  assign ch_is_cmp = ch_off[2];
  assign unused_bits = ^{wdata_i, ch_off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_o    <= '0;
      sel_o   <= SRC_OFF;
      en_o    <= '0;
      mod_o   <= '0;
      start_o <= '0;
      mask_o  <= '1;
      pol_o   <= '0;
    end else if (wr) begin
      case (addr_i)
        A_CTRL: begin
          ps_o  <= wdata_i[PS_W-1:0];
          sel_o <= src_e'(wdata_i[4:3]);
          en_o  <= wdata_i[16 +: NCH];
        end
        A_MOD:   mod_o   <= wdata_i[CNT_W-1:0];
        A_START: start_o <= wdata_i[CNT_W-1:0];
        A_MASK:  mask_o  <= wdata_i[NCH-1:0];
        A_POL:   pol_o   <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
        cmp_o[i] <= '0;
      end else if (wr && ch_hit && (ch_idx == IDX_W'(i))) begin
        if (ch_is_cmp) cmp_o[i] <= wdata_i[CNT_W-1:0];
        else           cfg_q[i] <= wdata_i[5:2];
      end
    end
    // edge-aligned PWM needs cfg bit 5 and bit 3
    assign mode_o[i] = cfg_q[i][3] & cfg_q[i][1];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (ch_hit) begin
        if (ch_is_cmp) rdata_o[CNT_W-1:0] = cmp_o[ch_idx];
        else           rdata_o[5:2]       = cfg_q[ch_idx];
      end else begin
        case (addr_i)
          A_CTRL: begin
            rdata_o[PS_W-1:0]   = ps_o;
            rdata_o[4:3]        = sel_o;
            rdata_o[16 +: NCH]  = en_o;
          end
          A_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
          A_MOD:   rdata_o[CNT_W-1:0] = mod_o;
          A_START: rdata_o[CNT_W-1:0] = start_o;
          A_MASK:  rdata_o[NCH-1:0]   = mask_o;
          A_POL:   rdata_o[NCH-1:0]   = pol_o;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             sel_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             fix_tick_i,
  input  logic             ext_tick_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] start_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic             src_en;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] low_mask;

  always_comb begin
    case (sel_i)
      SRC_SYS: src_en = 1'b1;
      SRC_FIX: src_en = fix_tick_i;
      SRC_EXT: src_en = ext_tick_i;
      default: src_en = 1'b0;
    endcase
  end

  always_comb begin
    for (int k = 0; k < DIV_W; k++) low_mask[k] = (k < int'(ps_i));
  end

  assign tick_o = src_en && ((div_q & low_mask) == low_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (sel_i == SRC_OFF) div_q <= '0;
    else if (src_en)           div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_o) cnt_o <= (cnt_o >= mod_i) ? start_i : cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mode_i,
  input  logic             en_i,
  input  logic             mask_i,
  input  logic             pol_i,
  output logic             out_o
);
  logic raw;
  assign raw   = mode_i & (cnt_i < cmp_i);
  assign out_o = (raw & en_i & ~mask_i) ^ pol_i;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fix_tick_i,
  input  logic              ext_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [PS_W-1:0]          ps;
  src_e                     clk_sel;
  logic [CNT_W-1:0]         mod_q;
  logic [CNT_W-1:0]         start_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     cnt_tick;
  logic [NCH-1:0]           ch_en;
  logic [NCH-1:0]           out_mask;
  logic [NCH-1:0]           out_pol;
  logic [NCH-1:0]           ch_mode;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;

  pwm_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_q),
    .rdata_o (rdata_o),
    .ps_o    (ps),
    .sel_o   (clk_sel),
    .mod_o   (mod_q),
    .start_o (start_q),
    .en_o    (ch_en),
    .mask_o  (out_mask),
    .pol_o   (out_pol),
    .mode_o  (ch_mode),
    .cmp_o   (cmp_q)
  );

  pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (clk_sel),
    .ps_i       (ps),
    .fix_tick_i (fix_tick_i),
    .ext_tick_i (ext_tick_i),
    .mod_i      (mod_q),
    .start_i    (start_q),
    .tick_o     (cnt_tick),
    .cnt_o      (cnt_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .cnt_i  (cnt_q),
      .cmp_i  (cmp_q[i]),
      .mode_i (ch_mode[i]),
      .en_i   (ch_en[i]),
      .mask_i (out_mask[i]),
      .pol_i  (out_pol[i]),
      .out_o  (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                sel_i,
  input logic                      fix_i,
  input logic                      ext_i,
  input logic                      tick_i,
  input logic [CNT_W-1:0]          cnt_i,
  input logic [CNT_W-1:0]          mod_i,
  input logic [CNT_W-1:0]          start_i,
  input logic [NCH-1:0][CNT_W-1:0] cmp_i,
  input logic [NCH-1:0]            mode_i,
  input logic [NCH-1:0]            en_i,
  input logic [NCH-1:0]            mask_i,
  input logic [NCH-1:0]            pol_i,
  input logic [NCH-1:0]            pwm_i
);
  logic [NCH-1:0] cmp_zero;
  logic [NCH-1:0] cmp_full;
  logic [NCH-1:0] live;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cmp_zero[i] = (cmp_i[i] == '0);
      cmp_full[i] = (cmp_i[i] > mod_i);
    end
  end
  assign live = mode_i & en_i & ~mask_i;

  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0) |=> (cnt_i == $past(cnt_i)));

  p_fix_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2 && !fix_i) |=> (cnt_i == $past(cnt_i)));

  p_ext_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd3 && !ext_i) |=> (cnt_i == $past(cnt_i)));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i >= mod_i) |=> (cnt_i == $past(start_i)));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i < mod_i) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_i ^ pol_i) & cmp_zero) == '0);

  p_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= mod_i) |-> ((~(pwm_i ^ pol_i) & cmp_full & live) == '0));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_i ^ pol_i) & (mask_i | ~en_i)) == '0);
endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (clk_sel),
  .fix_i   (fix_tick_i),
  .ext_i   (ext_tick_i),
  .tick_i  (cnt_tick),
  .cnt_i   (cnt_q),
  .mod_i   (mod_q),
  .start_i (start_q),
  .cmp_i   (cmp_q),
  .mode_i  (ch_mode),
  .en_i    (ch_en),
  .mask_i  (out_mask),
  .pol_i   (out_pol),
  .pwm_i   (pwm_o)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fix_t = 1'b0, ext_t = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pwm;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .fix_tick_i(fix_t), .ext_tick_i(ext_t),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  ps;
    logic [15:0] mod;
    logic [15:0] start;
    logic [15:0] cbase;
    logic [15:0] cstep;
    logic [7:0]  pol;
    logic [7:0]  mask;
    logic [7:0]  en;
    logic [5:0]  cfg;
    logic [11:0] cyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 3'd0, 16'd9,  16'd0, 16'd0, 16'd2, 8'h00, 8'h00, 8'hFF, 6'h28, 12'd60},
    '{2'd1, 3'd2, 16'd5,  16'd0, 16'd1, 16'd1, 8'hA5, 8'h00, 8'hFF, 6'h28, 12'd80},
    '{2'd1, 3'd0, 16'd12, 16'd4, 16'd3, 16'd2, 8'h00, 8'h00, 8'hFF, 6'h28, 12'd60},
    '{2'd2, 3'd1, 16'd7,  16'd2, 16'd2, 16'd1, 8'h0F, 8'h00, 8'hFF, 6'h28, 12'd100},
    '{2'd3, 3'd0, 16'd6,  16'd1, 16'd0, 16'd1, 8'hF0, 8'h00, 8'hFF, 6'h2C, 12'd80},
    '{2'd1, 3'd0, 16'd9,  16'd0, 16'd2, 16'd1, 8'h81, 8'h3C, 8'hF0, 6'h28, 12'd60},
    '{2'd1, 3'd0, 16'd5,  16'd0, 16'd3, 16'd0, 8'h00, 8'h00, 8'hFF, 6'h20, 12'd40},
    '{2'd1, 3'd0, 16'd5,  16'd0, 16'd3, 16'd0, 8'h44, 8'h00, 8'hFF, 6'h08, 12'd40},
    '{2'd1, 3'd0, 16'd5,  16'd0, 16'd1, 16'd1, 8'h00, 8'h00, 8'hFF, 6'h3C, 12'd40},
    '{2'd1, 3'd7, 16'd1,  16'd0, 16'd1, 16'd0, 8'h00, 8'h00, 8'hFF, 6'h28, 12'd600}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #500us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, c0;
    logic [15:0] m_cnt;
    logic [6:0]  m_div, lm;
    logic [15:0] cmp [8];
    logic [7:0]  lfsr, exp_o;
    logic        src, tk;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwm == 8'h00, "R1 pwm_o", {24'b0, pwm}, 32'h0);
    rd(8'h60, d); check(d == 32'hFF, "R1 mask", d, 32'hFF);
    rd(8'h00, d); check(d == 32'h0, "R1 ctrl", d, 32'h0);
    rd(8'h04, d); check(d == 32'h0, "R1 counter", d, 32'h0);
    rd(8'h70, d); check(d == 32'h0, "R1 polarity", d, 32'h0);

    // R11 readback of implemented fields
    wr(8'h08, 32'hFFFF1234); rd(8'h08, d); check(d == 32'h1234, "R11 modulo", d, 32'h1234);
    wr(8'h4C, 32'h00010077); rd(8'h4C, d); check(d == 32'h0077, "R11 restart", d, 32'h77);
    wr(8'h0C, 32'hFFFFFFFF); rd(8'h0C, d); check(d == 32'h3C, "R11 R7 cfg0 bits", d, 32'h3C);
    wr(8'h48, 32'hABCD5678); rd(8'h48, d); check(d == 32'h5678, "R11 R7 cmp7", d, 32'h5678);
    wr(8'h00, 32'hFFFFFFE7); rd(8'h00, d); check(d == 32'h00FF0007, "R11 ctrl", d, 32'h00FF0007);
    wr(8'h00, 32'h0);

    // R10 unimplemented and unaligned addresses
    foreach (VEC[i]) ; // keep list usage simple
    begin
      logic [7:0] holes [5] = '{8'h5C, 8'h50, 8'h80, 8'hFC, 8'h0A};
      foreach (holes[k]) begin
        wr(holes[k], 32'hFFFFFFFF);
        rd(holes[k], d);
        check(d == 32'h0, "R10 hole", d, 32'h0);
      end
      rd(8'h08, d); check(d == 32'h1234, "R10 unaligned write ignored", d, 32'h1234);
    end

    // table of configurations
    lfsr = 8'h5B;
    for (int v = 0; v < NV; v++) begin
      wr(8'h00, {8'h00, VEC[v].en, 11'b0, 2'b00, VEC[v].ps});
      wr(8'h08, {16'h0, VEC[v].mod});
      wr(8'h4C, {16'h0, VEC[v].start});
      wr(8'h60, {24'h0, VEC[v].mask});
      wr(8'h70, {24'h0, VEC[v].pol});
      for (int n = 0; n < 8; n++) begin
        cmp[n] = VEC[v].cbase + 16'(n) * VEC[v].cstep;
        wr(8'(12 + 8 * n), {26'h0, VEC[v].cfg});
        wr(8'(16 + 8 * n), {16'h0, cmp[n]});
      end
      rd(8'h04, d);
      m_cnt = d[15:0];
      m_div = '0;
      lm = 7'((8'd1 << VEC[v].ps) - 8'd1);
      wr(8'h00, {8'h00, VEC[v].en, 11'b0, VEC[v].sel, VEC[v].ps});
      req = 1'b1; we = 1'b0; addr = 8'h04;
      for (int c = 0; c < int'(VEC[v].cyc); c++) begin
        #1;
        check(rdata[15:0] == m_cnt, "R3 R4 R5 counter", rdata, {16'h0, m_cnt});
        for (int n = 0; n < 8; n++)
          exp_o[n] = (VEC[v].en[n] & ~VEC[v].mask[n] & VEC[v].cfg[5] & VEC[v].cfg[3]
                      & (m_cnt < cmp[n])) ^ VEC[v].pol[n];
        check(pwm == exp_o, "R6 R7 R8 R9 outputs", {24'h0, pwm}, {24'h0, exp_o});
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        fix_t = lfsr[0];
        ext_t = lfsr[3] ^ lfsr[1];
        case (VEC[v].sel)
          2'd1: src = 1'b1;
          2'd2: src = fix_t;
          2'd3: src = ext_t;
          default: src = 1'b0;
        endcase
        tk = src && ((m_div & lm) == lm);
        if (src) m_div = m_div + 7'd1;
        if (tk) m_cnt = (m_cnt >= VEC[v].mod) ? VEC[v].start : m_cnt + 16'd1;
        @(negedge clk);
      end
      fix_t = 1'b0; ext_t = 1'b0;
      wr(8'h00, {8'h00, VEC[v].en, 11'b0, 2'b00, VEC[v].ps});
    end

    // R2 stopped counter ignores tick inputs; R10 counter write ignored
    wr(8'h00, 32'h00FF0000);
    rd(8'h04, c0);
    fix_t = 1'b1; ext_t = 1'b1;
    repeat (20) @(negedge clk);
    fix_t = 1'b0; ext_t = 1'b0;
    rd(8'h04, d); check(d == c0, "R2 counter held", d, c0);
    wr(8'h04, 32'h00000055);
    rd(8'h04, d); check(d == c0, "R10 counter write ignored", d, c0);

    @(negedge clk);
    finish_run();
  end
endmodule